// File: doc/BRIEF.md
# Track Sector Decoder

This block takes the track words that a central tracking trigger delivers for twelve azimuthal sectors and turns them into sector bitmaps, one per charge sign and momentum bin. Each word carries a found flag, a charge-sign bit, a two-bit momentum bin code and a position field that locates the track inside its sector. All sectors are handled side by side. Within one bunch crossing each sector presents up to six words, one per slot. A crossing starts with a marker on its first slot.

For each crossing the block ORs every good track into a map of four bins × two signs × twelve sectors. After the sixth slot it presents that map with a one-cycle valid pulse. The map then stays unchanged until the next crossing completes. Each accepted word that carries a track is also passed on one cycle later, with its position, sign and bin, to the matching logic downstream.

Top module: `tsd_decoder`

## Requirements
- R1: After synchronous reset, `map_out`, `map_vld`, `fwd_vld`, `fwd_sign`, `fwd_bin` and `fwd_pos` are all zero.
- R2: An accepted word in sector s with found=1, sign g (0 positive, 1 negative) and bin code b (0..3) sets bit `(b*2+g)*12+s` of the crossing's map.
- R3: An accepted word with found=0 sets no map bit and raises no forwarding flag, whatever its sign, bin and position.
- R4: Map bits are OR-accumulated over the six slots of a crossing. Several tracks that hit the same bit leave it set.
- R5: The edge that accepts the sixth slot loads the finished map into `map_out` and raises `map_vld` for exactly one cycle. `map_out` holds its value until the next crossing completes.
- R6: A slot with `slot_vld` and `bx_first` both high starts a new crossing, and nothing from the earlier crossing appears in the new map.
- R7: A new `bx_first` before six slots have arrived drops the partial crossing without a valid pulse. Counting restarts from that slot.
- R8: A `slot_vld` without `bx_first` is ignored when no crossing is open: after reset, or once six slots are done. It changes no map bit, raises no pulse and forwards nothing.
- R9: For every accepted word with found=1, `fwd_vld[s]` is high in the next cycle, with `fwd_pos`, `fwd_sign` and `fwd_bin` equal to that word's fields. Otherwise `fwd_vld[s]` is low and those fields are zero.
- R10: The twelve sectors are independent. A track in one sector affects only that sector's bits and forwarding lane.
- R11: Cycles with `slot_vld` low do not count as slots. A crossing with idle cycles between its slots completes only on its sixth real slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | 1 | A slot of track words is present this cycle |
| bx_first | input | 1 | This slot is the first of a new crossing |
| trk_found | input | 12 | Per-sector track-found flag |
| trk_sign | input | 12 | Per-sector charge sign, 1 = negative |
| trk_bin | input | 24 | Per-sector 2-bit momentum bin code, sector s at bits [2s+1:2s] |
| trk_pos | input | 72 | Per-sector 6-bit position field, sector s at bits [6s+5:6s] |
| map_out | output | 96 | Crossing map, bit (bin*2+sign)*12+sector |
| map_vld | output | 1 | One-cycle pulse when `map_out` takes a finished crossing |
| fwd_vld | output | 12 | Forwarded track present per sector |
| fwd_sign | output | 12 | Forwarded sign per sector |
| fwd_bin | output | 24 | Forwarded bin code per sector |
| fwd_pos | output | 72 | Forwarded position field per sector |

## Verification
Two functions can fall in the same cycle: presenting the finished map of one crossing and clearing the accumulator for the next. The bench provokes this by driving the first slot of a new crossing in the very cycle `map_vld` is high. It then checks that the presented map belongs only to the old crossing, that the pulse drops after one cycle, and that the new crossing's map contains none of the old bits. A second case starts a new crossing inside a partial one, and the bench checks that no pulse appears and that the partial tracks are lost.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    localparam int TSD_NUM_BINS = 4;
    localparam int TSD_BIN_W    = 2;
    localparam int TSD_SIGNS    = 2;
    localparam int TSD_CODES    = TSD_NUM_BINS * TSD_SIGNS;
    localparam int TSD_CODE_W   = $clog2(TSD_CODES);

    typedef enum logic {
        SIGN_POS = 1'b0,
        SIGN_NEG = 1'b1
    } sign_e;

    typedef logic [TSD_BIN_W-1:0]  bin_t;
    typedef logic [TSD_CODES-1:0]  hits_t;
    typedef logic [TSD_CODE_W-1:0] code_t;

    // Header of one track word
    typedef struct packed {
        logic  found;
        sign_e sign;
        bin_t  bin;
    } trk_hdr_t;

    // Per-cycle slot decisions shared by all sectors
    typedef struct packed {
        logic accept;
        logic first;
        logic last;
    } slot_ctl_t;

    // Map position of a track inside a sector: bin-major, sign-minor
    function automatic code_t hit_code(trk_hdr_t h);
        return {h.bin, h.sign};
    endfunction

    function automatic hits_t hit_mask(trk_hdr_t h);
        hits_t m;
        m = '0;
        if (h.found)
            m[hit_code(h)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/tsd_slot_ctrl.sv
module tsd_slot_ctrl
    import tsd_pkg::*;
#(
    parameter int SLOTS = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      slot_vld,
    input  logic      bx_first,
    output slot_ctl_t ctl
);

    localparam int CNT_W = $clog2(SLOTS + 1);
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t CNT_IDLE = cnt_t'(SLOTS);
    localparam cnt_t CNT_LAST = cnt_t'(SLOTS - 1);
    localparam cnt_t CNT_ONE  = cnt_t'(1);

    cnt_t cnt;
    cnt_t cnt_nxt;

    always_comb begin
        ctl.first  = slot_vld && bx_first;
        ctl.accept = ctl.first || (slot_vld && (cnt != CNT_IDLE));
        if (ctl.first)
            ctl.last = (SLOTS == 1);
        else
            ctl.last = ctl.accept && (cnt == CNT_LAST);

        cnt_nxt = cnt;
        if (ctl.first)
            cnt_nxt = CNT_ONE;
        else if (ctl.accept)
            cnt_nxt = cnt + CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_IDLE;
        else
            cnt <= cnt_nxt;
    end

    // R8: the slot count never runs past the closed state
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_IDLE);

    // R11: an idle cycle leaves the slot position unchanged
    p_gap_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !slot_vld |=> $stable(cnt));

endmodule

// File: rtl/tsd_sector_acc.sv
module tsd_sector_acc
    import tsd_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_slot,
    input  logic             clear,
    input  trk_hdr_t         hdr,
    input  logic [POS_W-1:0] pos,
    output hits_t            acc_nxt,
    output logic             fwd_vld,
    output logic             fwd_sign,
    output bin_t             fwd_bin,
    output logic [POS_W-1:0] fwd_pos
);

    hits_t acc;
    hits_t base;
    hits_t add;
    code_t code;
    logic  keep;

    always_comb begin
        code    = hit_code(hdr);
        base    = clear ? '0 : acc;
        add     = take_slot ? hit_mask(hdr) : '0;
        acc_nxt = base | add;
        keep    = take_slot && hdr.found;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            fwd_vld  <= 1'b0;
            fwd_sign <= 1'b0;
            fwd_bin  <= '0;
            fwd_pos  <= '0;
        end else begin
            if (take_slot)
                acc <= acc_nxt;
            fwd_vld  <= keep;
            fwd_sign <= keep ? hdr.sign : 1'b0;
            fwd_bin  <= keep ? hdr.bin : '0;
            fwd_pos  <= keep ? pos : '0;
        end
    end

    // R2: an accepted good track leaves its bit set
    p_found_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (take_slot && hdr.found) |=> acc[$past(code)]);

    // R3: an empty word mid-crossing changes nothing
    p_nofound_r3: assert property (@(posedge clk) disable iff (rst)
        (take_slot && !clear && !hdr.found) |=> (acc == $past(acc)));

    // R9: forwarding only follows an accepted good track
    p_fwd_src_r9: assert property (@(posedge clk) disable iff (rst)
        fwd_vld |-> $past(take_slot && hdr.found));

endmodule

// File: rtl/tsd_decoder.sv
module tsd_decoder
    import tsd_pkg::*;
#(
    parameter int NSEC  = 12,
    parameter int SLOTS = 6,
    parameter int POS_W = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        slot_vld,
    input  logic                        bx_first,
    input  logic [NSEC-1:0]             trk_found,
    input  logic [NSEC-1:0]             trk_sign,
    input  logic [NSEC*TSD_BIN_W-1:0]   trk_bin,
    input  logic [NSEC*POS_W-1:0]       trk_pos,
    output logic [TSD_CODES*NSEC-1:0]   map_out,
    output logic                        map_vld,
    output logic [NSEC-1:0]             fwd_vld,
    output logic [NSEC-1:0]             fwd_sign,
    output logic [NSEC*TSD_BIN_W-1:0]   fwd_bin,
    output logic [NSEC*POS_W-1:0]       fwd_pos
);

    localparam int MAP_W = TSD_CODES * NSEC;

    slot_ctl_t        ctl;
    hits_t            sec_nxt [NSEC];
    logic [MAP_W-1:0] map_nxt;

    tsd_slot_ctrl #(.SLOTS(SLOTS)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .slot_vld (slot_vld),
        .bx_first (bx_first),
        .ctl      (ctl)
    );

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        trk_hdr_t hdr;
        bin_t     f_bin;

        always_comb begin
            hdr.found = trk_found[s];
            hdr.sign  = sign_e'(trk_sign[s]);
            hdr.bin   = trk_bin[s*TSD_BIN_W +: TSD_BIN_W];
        end

        tsd_sector_acc #(.POS_W(POS_W)) u_acc (
            .clk       (clk),
            .rst       (rst),
            .take_slot (ctl.accept),
            .clear     (ctl.first),
            .hdr       (hdr),
            .pos       (trk_pos[s*POS_W +: POS_W]),
            .acc_nxt   (sec_nxt[s]),
            .fwd_vld   (fwd_vld[s]),
            .fwd_sign  (fwd_sign[s]),
            .fwd_bin   (f_bin),
            .fwd_pos   (fwd_pos[s*POS_W +: POS_W])
        );

        assign fwd_bin[s*TSD_BIN_W +: TSD_BIN_W] = f_bin;

        for (genvar c = 0; c < TSD_CODES; c++) begin : g_code
            assign map_nxt[c*NSEC + s] = sec_nxt[s][c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_out <= '0;
            map_vld <= 1'b0;
        end else begin
            map_vld <= ctl.last;
            if (ctl.last)
                map_out <= map_nxt;
        end
    end

    // R5: the presented map changes only together with a pulse
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !map_vld |-> $stable(map_out));

    if (SLOTS > 1) begin : g_pulse_chk
        // R5: a completion pulse is never two cycles long
        p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
            map_vld |=> !map_vld);
    end

endmodule

// File: tb/test_tsd_decoder.sv
`timescale 1ns/1ps
module test_tsd_decoder;

    localparam int NSEC  = 12;
    localparam int SLOTS = 6;
    localparam int POS_W = 6;
    localparam int MAP_W = 8 * NSEC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slot_vld = 1'b0;
    logic bx_first = 1'b0;
    logic [NSEC-1:0]       t_found = '0;
    logic [NSEC-1:0]       t_sign  = '0;
    logic [NSEC*2-1:0]     t_bin   = '0;
    logic [NSEC*POS_W-1:0] t_pos   = '0;
    logic [MAP_W-1:0]      map_out;
    logic                  map_vld;
    logic [NSEC-1:0]       fwd_vld;
    logic [NSEC-1:0]       fwd_sign;
    logic [NSEC*2-1:0]     fwd_bin;
    logic [NSEC*POS_W-1:0] fwd_pos;

    int checks = 0;
    int errors = 0;
    logic [MAP_W-1:0] exp_map;
    logic [MAP_W-1:0] old_map;

    always #10 clk = ~clk;

    tsd_decoder #(.NSEC(NSEC), .SLOTS(SLOTS), .POS_W(POS_W)) i_tsd_decoder (
        .clk(clk), .rst(rst), .slot_vld(slot_vld), .bx_first(bx_first),
        .trk_found(t_found), .trk_sign(t_sign), .trk_bin(t_bin), .trk_pos(t_pos),
        .map_out(map_out), .map_vld(map_vld), .fwd_vld(fwd_vld),
        .fwd_sign(fwd_sign), .fwd_bin(fwd_bin), .fwd_pos(fwd_pos)
    );

    typedef struct packed {
        logic [3:0] sec;
        logic [2:0] slot;
        logic       found;
        logic       sign;
        logic [1:0] bin;
        logic [5:0] pos;
        logic [6:0] idx;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd0,  3'd0, 1'b1, 1'b0, 2'd0, 6'd5,  7'd0},
        '{4'd11, 3'd5, 1'b1, 1'b1, 2'd3, 6'd63, 7'd95},
        '{4'd5,  3'd2, 1'b1, 1'b1, 2'd1, 6'd17, 7'd41},
        '{4'd7,  3'd3, 1'b1, 1'b0, 2'd2, 6'd33, 7'd55},
        '{4'd3,  3'd4, 1'b0, 1'b1, 2'd2, 6'd44, 7'd0},
        '{4'd9,  3'd1, 1'b1, 1'b0, 2'd3, 6'd2,  7'd81},
        '{4'd2,  3'd5, 1'b1, 1'b1, 2'd0, 6'd50, 7'd14},
        '{4'd6,  3'd0, 1'b0, 1'b0, 2'd1, 6'd9,  7'd0}
    };

    task automatic check(input logic ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_trk();
        t_found = '0; t_sign = '0; t_bin = '0; t_pos = '0;
    endtask

    task automatic set_trk(input int s, input logic f, input logic g,
                           input logic [1:0] b, input logic [5:0] p);
        t_found[s] = f;
        t_sign[s]  = g;
        t_bin[s*2 +: 2] = b;
        t_pos[s*POS_W +: POS_W] = p;
    endtask

    function automatic logic [MAP_W-1:0] bit_of(input int s, input logic g,
                                                  input logic [1:0] b);
        logic [MAP_W-1:0] m;
        m = '0;
        m[(int'(b) * 2 + int'(g)) * NSEC + s] = 1'b1;
        return m;
    endfunction

    // Called at a negedge; returns at the negedge after the accepting edge
    task automatic drive_slot(input logic first);
        slot_vld = 1'b1;
        bx_first = first;
        @(negedge clk);
        slot_vld = 1'b0;
        bx_first = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(map_out == '0 && map_vld == 1'b0, "R1 map", {map_vld, map_out}, '0);
        check(fwd_vld == '0 && fwd_pos == '0 && fwd_bin == '0 && fwd_sign == '0,
              "R1 fwd", {fwd_vld, fwd_pos}, '0);

        // R8: slots with no open crossing after reset
        set_trk(4, 1'b1, 1'b1, 2'd2, 6'd7);
        for (int k = 0; k < 7; k++) begin
            drive_slot(1'b0);
            check(map_vld == 1'b0 && fwd_vld == '0, "R8 idle slot",
                  {fwd_vld, map_vld}, '0);
        end
        clear_trk();

        // Table walk: R2, R3, R9 with one word per crossing
        foreach (VECS[i]) begin
            for (int sl = 0; sl < SLOTS; sl++) begin
                clear_trk();
                if (sl == int'(VECS[i].slot))
                    set_trk(int'(VECS[i].sec), VECS[i].found, VECS[i].sign,
                            VECS[i].bin, VECS[i].pos);
                drive_slot(sl == 0);
                if (sl == int'(VECS[i].slot)) begin
                    if (VECS[i].found)
                        check(fwd_vld == (12'd1 << VECS[i].sec) &&
                              fwd_pos[VECS[i].sec*POS_W +: POS_W] == VECS[i].pos &&
                              fwd_bin[VECS[i].sec*2 +: 2] == VECS[i].bin &&
                              fwd_sign[VECS[i].sec] == VECS[i].sign,
                              "R9 forward", {fwd_vld, fwd_pos}, {VECS[i].sec, VECS[i].pos});
                    else
                        check(fwd_vld == '0 && fwd_pos == '0, "R3 no forward",
                              {fwd_vld, fwd_pos}, '0);
                end
            end
            exp_map = VECS[i].found ? (96'd1 << VECS[i].idx) : '0;
            check(map_vld == 1'b1, "R5 pulse", map_vld, 1);
            check(map_out == exp_map, VECS[i].found ? "R2 bit" : "R3 no bit",
                  map_out, exp_map);
        end
        clear_trk();

        // R4/R10: all sectors, repeated and mixed tracks
        exp_map = '0;
        for (int sl = 0; sl < SLOTS; sl++) begin
            clear_trk();
            for (int s = 0; s < NSEC; s++) begin
                logic g;
                logic [1:0] b;
                g = logic'((s + sl) % 2);
                b = 2'((s * 3 + sl) % 4);
                if (((s + sl) % 3) != 0) begin
                    set_trk(s, 1'b1, g, b, 6'(s + sl));
                    exp_map |= bit_of(s, g, b);
                end else begin
                    set_trk(s, 1'b0, g, b, 6'(s));
                end
            end
            drive_slot(sl == 0);
        end
        check(map_vld == 1'b1 && map_out == exp_map, "R4 R10 accumulate",
              map_out, exp_map);
        old_map = exp_map;

        // Collision: new crossing starts in the pulse cycle (R5, R6)
        clear_trk();
        set_trk(1, 1'b1, 1'b0, 2'd1, 6'd3);
        drive_slot(1'b1);
        check(map_vld == 1'b0, "R5 pulse width", map_vld, 0);
        check(map_out == old_map, "R5 hold", map_out, old_map);
        clear_trk();
        for (int sl = 1; sl < SLOTS; sl++) begin
            drive_slot(1'b0);
            if (sl < SLOTS - 1)
                check(map_vld == 1'b0 && map_out == old_map, "R5 hold mid",
                      map_out, old_map);
        end
        exp_map = bit_of(1, 1'b0, 2'd1);
        check(map_vld == 1'b1 && map_out == exp_map, "R6 clear", map_out, exp_map);
        old_map = exp_map;

        // R8: extra slots after completion
        set_trk(8, 1'b1, 1'b1, 2'd3, 6'd20);
        for (int k = 0; k < 3; k++) begin
            drive_slot(1'b0);
            check(map_vld == 1'b0 && fwd_vld == '0 && map_out == old_map,
                  "R8 extra slot", {fwd_vld, map_vld}, '0);
        end
        clear_trk();

        // R7: early restart drops partial crossing
        set_trk(10, 1'b1, 1'b1, 2'd2, 6'd1);
        drive_slot(1'b1);
        drive_slot(1'b0);
        drive_slot(1'b0);
        check(map_vld == 1'b0, "R7 no pulse partial", map_vld, 0);
        clear_trk();
        set_trk(0, 1'b1, 1'b1, 2'd3, 6'd4);
        drive_slot(1'b1);
        clear_trk();
        for (int sl = 1; sl < SLOTS; sl++) begin
            check(map_vld == 1'b0, "R7 restart count", map_vld, 0);
            drive_slot(1'b0);
        end
        exp_map = bit_of(0, 1'b1, 2'd3);
        check(map_vld == 1'b1 && map_out == exp_map, "R7 partial dropped",
              map_out, exp_map);

        // R11: idle gaps between slots
        set_trk(6, 1'b1, 1'b0, 2'd0, 6'd11);
        for (int sl = 0; sl < SLOTS; sl++) begin
            drive_slot(sl == 0);
            clear_trk();
            repeat (2) begin
                @(negedge clk);
                check(map_vld == 1'b0, "R11 gap", map_vld, 0);
            end
        end
        clear_trk();
        drive_slot(1'b1);
        check(map_vld == 1'b0, "R11 no early pulse", map_vld, 0);
        for (int sl = 1; sl < SLOTS; sl++) drive_slot(1'b0);
        check(map_vld == 1'b1 && map_out == '0, "R11 empty crossing", map_out, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule